// File: doc/BRIEF.md
# Management Serial Frame Decoder (PHY side)

This block sits on the PHY side of a two-wire style management link whose host drives every edge by writing a 32-bit control word. Each accepted write-direction word carries one serial bit. A bit-serial state machine walks through the frame start, the opcode, a 5-bit PHY address, a 5-bit register address and, for writes, a turnaround pair and 16 data bits. The addressed entry of a 32-by-32 array of 16-bit registers is then read or written.

For a read, the selected value is loaded into a 32-bit output shift register with one leading dummy bit. The host then collects it one bit per read-direction control word on the `rx_bit` output. Register 1 of every PHY address is a link-status register. Its value comes from the `link_up` input and not from the array.

Top module: `mgmt_frame_decoder`

## Requirements
- R1: After reset `rx_bit` is 0 and every entry of the register array reads back as 0x0000.
- R2: With `ctl_wr` high, bit 17 is masked out of `ctl_word`. If the rest equals exactly bits 16 and 13 (0x0001_2000), one serial input bit equal to bit 17 is accepted. If the rest equals exactly bits 18, 16 and 14 (0x0005_4000), one output bit is popped. Any other word has no effect on the frame or on the output shifter.
- R3: While idle, an input 1 keeps the decoder idle and an input 0 advances it. After that 0, a 1 completes the start and a 0 returns to idle.
- R4: The two bits after the start select the operation. 1 then 0 selects read, 0 then 1 selects write, and any other pair returns the decoder to idle with no access.
- R5: The next 5 bits form the PHY address and the following 5 bits form the register address, each received MSB first.
- R6: When a read's register address is complete, the output shifter is loaded with the 16-bit value at bit positions 30..15, with zeros elsewhere. Each pop first presents bit 31 on `rx_bit` and then shifts left by one. The first pop therefore yields a 0 dummy, the next 16 pops yield the value MSB first, and later pops yield 0.
- R7: In a write, the two bits after the register address must be 1 then 0. Any other pair returns the decoder to idle and no register is written.
- R8: After a valid turnaround, 16 data bits are received MSB first and stored into the addressed register.
- R9: A read of register address 1, at any PHY address, returns 0x0004 while `link_up` is 1 and 0x0000 while it is 0, regardless of what was written there.
- R10: Each PHY address has its own 32 registers, so a write to one PHY address leaves the same register number at another PHY address unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr | input | 1 | Host writes the control word this cycle |
| ctl_word | input | 32 | Control word written by the host |
| link_up | input | 1 | Link indication shown in register 1 |
| rx_bit | output | 1 | Last bit popped from the output shifter |

## Verification
The assertions check the following on every cycle:
- an idle 1 holds the decoder idle;
- a 1,1 opcode aborts;
- a bad second turnaround bit aborts;
- read and write launches are single, mutually exclusive pulses;
- a launched write lands in the addressed array entry;
- a read load places the value under a zero dummy bit;
- each pop shows the old top bit;
- a read of register 1 loads the link value.

Only the bench's scenarios can show the following:
- the exact masking of the control word;
- end-to-end MSB-first ordering of the address and data fields;
- separation between PHY addresses;
- that aborted frames leave the register array untouched, which the bench confirms by reading the targeted entries back over the serial link.

// File: rtl/mfd_pkg.sv
package mfd_pkg;

  localparam int CTL_W = 32;

  typedef enum logic [3:0] {
    S_IDLE,
    S_ZERO,
    S_START,
    S_OPHI,
    S_OPLO,
    S_ADDR,
    S_TA1,
    S_TA2,
    S_DATA
  } fsm_state_t;

  // Compare a control word against a pattern, ignoring the bits in ign.
  function automatic logic word_match(input logic [CTL_W-1:0] word,
                                      input logic [CTL_W-1:0] ign,
                                      input logic [CTL_W-1:0] pattern);
    return (word & ~ign) == pattern;
  endfunction

endpackage

// File: rtl/mfd_ctl_decode.sv
module mfd_ctl_decode
  import mfd_pkg::*;
#(
  parameter int CLK_BIT = 16,
  parameter int WEN_BIT = 13,
  parameter int REN_BIT = 14,
  parameter int MRD_BIT = 18,
  parameter int TXD_BIT = 17
) (
  input  logic             ctl_wr,
  input  logic [CTL_W-1:0] ctl_word,
  output logic             sample,
  output logic             pop,
  output logic             din
);

  localparam logic [CTL_W-1:0] IGN_MASK = CTL_W'(1) << TXD_BIT;
  localparam logic [CTL_W-1:0] PAT_IN   = (CTL_W'(1) << CLK_BIT) | (CTL_W'(1) << WEN_BIT);
  localparam logic [CTL_W-1:0] PAT_POP  = (CTL_W'(1) << CLK_BIT) | (CTL_W'(1) << MRD_BIT)
                                        | (CTL_W'(1) << REN_BIT);

  always_comb begin
    sample = ctl_wr && word_match(ctl_word, IGN_MASK, PAT_IN);
    pop    = ctl_wr && word_match(ctl_word, IGN_MASK, PAT_POP);
    din    = ctl_word[TXD_BIT];
  end

endmodule

// File: rtl/mfd_frame_fsm.sv
module mfd_frame_fsm
  import mfd_pkg::*;
#(
  parameter int PHY_AW = 5,
  parameter int REG_AW = 5,
  parameter int DW     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample,
  input  logic              din,
  output logic              rd_go,
  output logic              wr_go,
  output logic [PHY_AW-1:0] phy_addr,
  output logic [REG_AW-1:0] reg_addr,
  output logic [DW-1:0]     wdata
);

  localparam int AW_T = PHY_AW + REG_AW;
  localparam int CMAX = (AW_T > DW) ? AW_T : DW;
  localparam int CW   = $clog2(CMAX) + 1;

  fsm_state_t        st;
  logic              is_wr;
  logic [CW-1:0]     cnt;
  logic [AW_T-1:0]   addr_acc;
  logic [DW-1:0]     data_acc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      is_wr    <= 1'b0;
      cnt      <= '0;
      addr_acc <= '0;
      data_acc <= '0;
      rd_go    <= 1'b0;
      wr_go    <= 1'b0;
    end else begin
      rd_go <= 1'b0;
      wr_go <= 1'b0;
      if (sample) begin
        unique case (st)
          S_IDLE: begin
            addr_acc <= '0;
            data_acc <= '0;
            cnt      <= '0;
            st       <= din ? S_IDLE : S_ZERO;
          end
          S_ZERO:  st <= din ? S_START : S_IDLE;
          S_START: st <= din ? S_OPHI : S_OPLO;
          S_OPHI: begin
            is_wr <= 1'b0;
            st    <= din ? S_IDLE : S_ADDR;
          end
          S_OPLO: begin
            is_wr <= 1'b1;
            st    <= din ? S_ADDR : S_IDLE;
          end
          S_ADDR: begin
            addr_acc <= {addr_acc[AW_T-2:0], din};
            if (cnt == CW'(AW_T - 1)) begin
              cnt <= '0;
              if (is_wr) begin
                st <= S_TA1;
              end else begin
                rd_go <= 1'b1;
                st    <= S_IDLE;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_TA1: st <= din ? S_TA2 : S_IDLE;
          S_TA2: st <= din ? S_IDLE : S_DATA;
          S_DATA: begin
            data_acc <= {data_acc[DW-2:0], din};
            if (cnt == CW'(DW - 1)) begin
              cnt   <= '0;
              wr_go <= 1'b1;
              st    <= S_IDLE;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  assign phy_addr = addr_acc[AW_T-1:REG_AW];
  assign reg_addr = addr_acc[REG_AW-1:0];
  assign wdata    = data_acc;

  // R3: an idle 1 keeps the decoder idle
  a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (sample && st == S_IDLE && din) |=> (st == S_IDLE));

  // R4: opcode 1,1 aborts
  a_r4_bad_opcode: assert property (@(posedge clk) disable iff (!rst_n)
    (sample && st == S_OPHI && din) |=> (st == S_IDLE));

  // R7: second turnaround bit of 1 aborts the write
  a_r7_ta_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (sample && st == S_TA2 && din) |=> (st == S_IDLE && !wr_go));

  // R8: a write launch is a single-cycle pulse
  a_r8_wr_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wr_go |=> !wr_go);

  // R6: read and write launches never coincide
  a_r6_go_excl: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_go, wr_go}));

endmodule

// File: rtl/mfd_reg_array.sv
module mfd_reg_array #(
  parameter int          PHY_AW   = 5,
  parameter int          REG_AW   = 5,
  parameter int          DW       = 16,
  parameter int          LINK_REG = 1,
  parameter logic [15:0] LINK_VAL = 16'h0004
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_go,
  input  logic [PHY_AW-1:0] phy_addr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DW-1:0]     wdata,
  input  logic              link_up,
  output logic [DW-1:0]     rd_data
);

  localparam int IW    = PHY_AW + REG_AW;
  localparam int DEPTH = 1 << IW;

  function automatic logic [IW-1:0] flat_idx(input logic [PHY_AW-1:0] p,
                                             input logic [REG_AW-1:0] r);
    return {p, r};
  endfunction

  logic [DW-1:0] mem [DEPTH];
  logic [IW-1:0] idx;

  assign idx = flat_idx(phy_addr, reg_addr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_go) begin
      mem[idx] <= wdata;
    end
  end

  always_comb begin
    if (reg_addr == REG_AW'(LINK_REG)) rd_data = link_up ? DW'(LINK_VAL) : '0;
    else                               rd_data = mem[idx];
  end

  // R8: a launched write lands in the addressed entry
  a_r8_store: assert property (@(posedge clk) disable iff (!rst_n)
    wr_go |=> (mem[$past(idx)] == $past(wdata)));

endmodule

// File: rtl/mfd_out_shifter.sv
module mfd_out_shifter #(
  parameter int SW = 32,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] load_val,
  input  logic          pop,
  output logic          rx_bit,
  output logic [SW-1:0] sh_word
);

  localparam int LSH = SW - 1 - DW;

  logic [SW-1:0] sh;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh     <= '0;
      rx_bit <= 1'b0;
    end else if (load) begin
      sh <= SW'(load_val) << LSH;
    end else if (pop) begin
      rx_bit <= sh[SW-1];
      sh     <= {sh[SW-2:0], 1'b0};
    end
  end

  assign sh_word = sh;

  // R6: a load puts the value under a zero dummy bit
  a_r6_load: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (sh_word[SW-1] == 1'b0 && sh_word[SW-2 -: DW] == $past(load_val)));

  // R6: each pop shows the previous top bit
  a_r6_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !load) |=> (rx_bit == $past(sh_word[SW-1])));

endmodule

// File: rtl/mgmt_frame_decoder.sv
module mgmt_frame_decoder
  import mfd_pkg::*;
#(
  parameter int          PHY_AW   = 5,
  parameter int          REG_AW   = 5,
  parameter int          DW       = 16,
  parameter int          SW       = 32,
  parameter int          LINK_REG = 1,
  parameter logic [15:0] LINK_VAL = 16'h0004
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_wr,
  input  logic [CTL_W-1:0] ctl_word,
  input  logic             link_up,
  output logic             rx_bit
);

  logic              sample, pop, din;
  logic              rd_go, wr_go;
  logic [PHY_AW-1:0] phy_addr;
  logic [REG_AW-1:0] reg_addr;
  logic [DW-1:0]     wdata, rd_data;
  logic [SW-1:0]     sh_word;

  mfd_ctl_decode u_dec (
    .ctl_wr(ctl_wr), .ctl_word(ctl_word),
    .sample(sample), .pop(pop), .din(din)
  );

  mfd_frame_fsm #(.PHY_AW(PHY_AW), .REG_AW(REG_AW), .DW(DW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .sample(sample), .din(din),
    .rd_go(rd_go), .wr_go(wr_go),
    .phy_addr(phy_addr), .reg_addr(reg_addr), .wdata(wdata)
  );

  mfd_reg_array #(.PHY_AW(PHY_AW), .REG_AW(REG_AW), .DW(DW),
                  .LINK_REG(LINK_REG), .LINK_VAL(LINK_VAL)) u_arr (
    .clk(clk), .rst_n(rst_n), .wr_go(wr_go),
    .phy_addr(phy_addr), .reg_addr(reg_addr), .wdata(wdata),
    .link_up(link_up), .rd_data(rd_data)
  );

  mfd_out_shifter #(.SW(SW), .DW(DW)) u_sh (
    .clk(clk), .rst_n(rst_n), .load(rd_go), .load_val(rd_data),
    .pop(pop), .rx_bit(rx_bit), .sh_word(sh_word)
  );

  // R9: a read of the link register loads the link indication
  a_r9_link: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_go && reg_addr == REG_AW'(LINK_REG)) |=>
      (sh_word[SW-2 -: DW] == ($past(link_up) ? DW'(LINK_VAL) : '0)));

endmodule

// File: tb/mgmt_frame_decoder_bench.sv
module mgmt_frame_decoder_bench;

  localparam logic [31:0] W_IN  = 32'h0001_2000;
  localparam logic [31:0] W_POP = 32'h0005_4000;
  localparam logic [31:0] B17   = 32'h0002_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_wr = 1'b0;
  logic [31:0] ctl_word = '0;
  logic        link_up = 1'b0;
  logic        rx_bit;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  mgmt_frame_decoder u_mgmt_frame_decoder (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_word(ctl_word),
    .link_up(link_up), .rx_bit(rx_bit)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic put_word(input logic [31:0] w);
    @(negedge clk);
    ctl_wr   = 1'b1;
    ctl_word = w;
    @(negedge clk);
    ctl_wr   = 1'b0;
    ctl_word = '0;
  endtask

  task automatic send_bit(input logic b, input logic [31:0] extra);
    put_word(W_IN | (b ? B17 : 32'h0) | extra);
  endtask

  task automatic pop_bit(input logic [31:0] extra, output logic b);
    put_word(W_POP | extra);
    b = rx_bit;
  endtask

  task automatic send_frame(input logic [1:0] op, input logic [4:0] phy,
                            input logic [4:0] rg, input logic tail,
                            input logic [1:0] ta, input logic [15:0] data,
                            input logic [31:0] extra);
    send_bit(1'b0, extra);
    send_bit(1'b1, extra);
    send_bit(op[1], extra);
    send_bit(op[0], extra);
    for (int i = 4; i >= 0; i--) send_bit(phy[i], extra);
    for (int i = 4; i >= 0; i--) send_bit(rg[i], extra);
    if (tail) begin
      send_bit(ta[1], extra);
      send_bit(ta[0], extra);
      for (int i = 15; i >= 0; i--) send_bit(data[i], extra);
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic write_reg(input logic [4:0] phy, input logic [4:0] rg,
                           input logic [15:0] data);
    send_frame(2'b01, phy, rg, 1'b1, 2'b10, data, 32'h0);
  endtask

  task automatic read_reg(input logic [4:0] phy, input logic [4:0] rg,
                          output logic [15:0] val, output logic dummy);
    logic b;
    send_frame(2'b10, phy, rg, 1'b0, 2'b00, 16'h0, 32'h0);
    pop_bit(B17, dummy);
    val = '0;
    for (int i = 0; i < 16; i++) begin
      pop_bit(32'h0, b);
      val = {val[14:0], b};
    end
  endtask

  task automatic t_reset;
    logic [15:0] v; logic d;
    check("R1 rx_bit after reset", int'(rx_bit), 0);
    read_reg(5'd0, 5'd5, v, d);
    check("R1 array entry after reset", int'(v), 0);
    read_reg(5'd31, 5'd31, v, d);
    check("R1 last array entry after reset", int'(v), 0);
  endtask

  task automatic t_write_read;
    logic [15:0] v; logic d; logic b;
    write_reg(5'd3, 5'd7, 16'hA5C3);
    read_reg(5'd3, 5'd7, v, d);
    check("R6 dummy first bit", int'(d), 0);
    check("R5 R8 write then read", int'(v), 16'hA5C3);
    pop_bit(32'h0, b);
    check("R6 pop after value", int'(b), 0);
    write_reg(5'd17, 5'd22, 16'h8001);
    read_reg(5'd17, 5'd22, v, d);
    check("R8 second pattern", int'(v), 16'h8001);
  endtask

  task automatic t_phy_separate;
    logic [15:0] v; logic d;
    write_reg(5'd4, 5'd7, 16'h1234);
    read_reg(5'd3, 5'd7, v, d);
    check("R10 other PHY unchanged", int'(v), 16'hA5C3);
    read_reg(5'd4, 5'd7, v, d);
    check("R10 own PHY value", int'(v), 16'h1234);
  endtask

  task automatic t_link;
    logic [15:0] v; logic d;
    link_up = 1'b1;
    read_reg(5'd0, 5'd1, v, d);
    check("R9 link up", int'(v), 16'h0004);
    write_reg(5'd9, 5'd1, 16'hFFFF);
    read_reg(5'd9, 5'd1, v, d);
    check("R9 link register ignores stored value", int'(v), 16'h0004);
    link_up = 1'b0;
    read_reg(5'd9, 5'd1, v, d);
    check("R9 link down", int'(v), 16'h0000);
  endtask

  task automatic t_bad_start;
    logic [15:0] v; logic d;
    send_bit(1'b1, 32'h0);
    send_bit(1'b1, 32'h0);
    send_bit(1'b0, 32'h0);
    send_bit(1'b0, 32'h0);
    send_bit(1'b1, 32'h0);
    write_reg(5'd6, 5'd2, 16'h5A5A);
    read_reg(5'd6, 5'd2, v, d);
    check("R3 frame after idle ones and 0,0", int'(v), 16'h5A5A);
  endtask

  task automatic t_bad_opcode;
    logic [15:0] v; logic d;
    send_frame(2'b11, 5'd2, 5'd9, 1'b1, 2'b10, 16'hBEEF, 32'h0);
    read_reg(5'd2, 5'd9, v, d);
    check("R4 opcode 1,1 makes no write", int'(v), 0);
  endtask

  task automatic t_bad_ta;
    logic [15:0] v; logic d;
    send_frame(2'b01, 5'd8, 5'd8, 1'b1, 2'b11, 16'hFFFF, 32'h0);
    read_reg(5'd8, 5'd8, v, d);
    check("R7 turnaround 1,1 makes no write", int'(v), 0);
    send_frame(2'b01, 5'd8, 5'd8, 1'b1, 2'b00, 16'hFFFF, 32'h0);
    read_reg(5'd8, 5'd8, v, d);
    check("R7 turnaround 0,0 makes no write", int'(v), 0);
  endtask

  task automatic t_decode;
    logic [15:0] v; logic d; logic b;
    send_frame(2'b01, 5'd10, 5'd11, 1'b1, 2'b10, 16'h7E7E, 32'h0000_0001);
    read_reg(5'd10, 5'd11, v, d);
    check("R2 words with extra bit make no write", int'(v), 0);
    write_reg(5'd12, 5'd13, 16'hC00C);
    send_frame(2'b10, 5'd12, 5'd13, 1'b0, 2'b00, 16'h0, 32'h0);
    pop_bit(32'h0000_0100, b);
    pop_bit(32'h0000_0100, b);
    pop_bit(32'h0, b);
    check("R2 extra-bit pops ignored, dummy still first", int'(b), 0);
    pop_bit(32'h0, b);
    check("R2 first value bit after ignored pops", int'(b), 1);
    put_word(W_POP & ~32'h0004_0000);
    pop_bit(32'h0, b);
    check("R2 pop missing read bit ignored", int'(b), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write_read();
    t_phy_separate();
    t_link();
    t_bad_start();
    t_bad_opcode();
    t_bad_ta();
    t_decode();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule